// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Control

This block holds the two byte queues of a 16550-style serial port and the write-only control register that governs them. The host loads transmit bytes and unloads received bytes. The serializer takes bytes out of the transmit queue, and the deserializer puts bytes into the receive queue. A single control write at byte address 2 does several things. It switches both queues between a 16-deep mode and a single-byte holding mode. It can empty either queue on command. It also selects how many received bytes raise the receive-threshold interrupt.

When FIFO mode is off, each direction holds only one byte. Leaving FIFO mode empties both queues. The clear commands act on the queues only. The shift registers live outside this block and are never touched. The receive side keeps a sticky overrun flag for bytes that arrive when the queue is full.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, FIFO mode is off, both counts are 0, both data outputs are 0, and the interrupt and overrun flags are 0.
- R2: A control write (address 2) with bit 0 set turns FIFO mode on, which gives each queue a capacity of 16 bytes from the following cycle.
- R3: A control write with bit 0 clear turns FIFO mode off and empties both queues and the overrun flag in the same cycle. The other bits of that write are not applied.
- R4: A control write with bits 0 and 1 set empties the receive queue and clears overrun. The transmit queue is unaffected.
- R5: A control write with bits 0 and 2 set empties the transmit queue. The receive queue is unaffected.
- R6: Bits 7:6 of an enabling control write set the receive trigger level: 00 means 1, 01 means 4, 10 means 8 and 11 means 14. The interrupt is high exactly when FIFO mode is on and the receive count is at or above that level.
- R7: Bit 3 and bits 5:4 of a control write have no effect. Writes to any address other than 2 are ignored.
- R8: With FIFO mode off, each queue holds at most one byte.
- R9: Bytes leave each queue in arrival order. A successful pop places the oldest byte on the data output in the cycle after the pop.
- R10: A receive push while the queue is full is dropped and sets the sticky overrun flag.
- R11: A pop from an empty queue leaves the count and the data output unchanged.
- R12: A clear in the same cycle as a push or pop on that queue leaves its count at 0.
- R13: A transmit push while the queue is full is dropped and the count stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register byte address |
| cfgData | input | 8 | Register write data |
| hostTxWe | input | 1 | Host pushes a transmit byte |
| hostTxData | input | 8 | Transmit byte from host |
| serTxPop | input | 1 | Serializer takes a transmit byte |
| txData | output | 8 | Last byte taken from transmit queue |
| txCount | output | 5 | Transmit queue occupancy |
| desRxPush | input | 1 | Deserializer pushes a received byte |
| desRxData | input | 8 | Received byte |
| hostRxPop | input | 1 | Host takes a received byte |
| rxData | output | 8 | Last byte taken from receive queue |
| rxCount | output | 5 | Receive queue occupancy |
| rxIrq | output | 1 | Receive threshold reached |
| rxOverrun | output | 1 | Sticky receive overrun flag |
| fifoMode | output | 1 | FIFO mode currently on |

## Verification
The queues are tested by filling them to capacity in both modes, by popping from empty queues, and by clears that coincide with pushes or pops. These patterns separate correct capacity, drop and clear-priority behaviour from off-by-one or ordering faults. Each of the four trigger codes is stepped across its threshold one byte at a time, which exposes a wrong level or a wrong comparison. Control writes with bit 0 clear, writes with only bit 3 set, and writes to other addresses show whether gating and address decoding are correct. A long stretch of random traffic is then compared on every cycle against queue models, to catch ordering and count drift.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  // Strobes from the control register to the two queues.
  typedef struct packed {
    logic       fifoEn;   // registered mode bit
    logic       flushTx;  // one-cycle pulse
    logic       flushRx;  // one-cycle pulse
    logic [1:0] trigSel;  // receive trigger code
  } ctrlStrobes_t;
endpackage

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
  import uart_fifo_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output ctrlStrobes_t      strb
);
  logic       hit;
  logic       enQ;
  logic [1:0] trigQ;
  logic       unusedCfgBits;

  assign hit = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
  // DMA select and reserved bits are accepted and dropped.
  assign unusedCfgBits = ^wrData[5:3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      trigQ <= 2'b00;
    end else if (hit) begin
      enQ <= wrData[0];
      if (wrData[0]) trigQ <= wrData[7:6];
    end
  end

  always_comb begin
    strb.fifoEn  = enQ;
    strb.trigSel = trigQ;
    // Disabling empties both queues; enabled writes may clear each one.
    strb.flushRx = hit && (!wrData[0] || wrData[1]);
    strb.flushTx = hit && (!wrData[0] || wrData[2]);
  end

  assert_gated_trig_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !wrData[0]) |=> (trigQ == $past(trigQ)));
  assert_disable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !wrData[0]) |=> !enQ);
endmodule

// File: rtl/uart_fifo_store.sv
module uart_fifo_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CNT_W-1:0] count,
  output logic             dropped
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cap;
  logic             pushOk, popOk;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap     = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign pushOk  = push && !flush && (count < cap);
  assign popOk   = pop && !flush && (count != '0);
  assign dropped = push && !flush && (count >= cap);

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      popData <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk) begin
        rdPtr   <= nextPtr(rdPtr);
        popData <= mem[rdPtr];
      end
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    count <= cap);
  assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
  assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && !flush && count == '0) |=> ($stable(count) && $stable(popData)));
  assert_full_drop_R13: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !flush && count == cap) |=> (count == $past(count)));
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [7:0]        cfgData,
  input  logic              hostTxWe,
  input  logic [7:0]        hostTxData,
  input  logic              serTxPop,
  output logic [7:0]        txData,
  output logic [CNT_W-1:0]  txCount,
  input  logic              desRxPush,
  input  logic [7:0]        desRxData,
  input  logic              hostRxPop,
  output logic [7:0]        rxData,
  output logic [CNT_W-1:0]  rxCount,
  output logic              rxIrq,
  output logic              rxOverrun,
  output logic              fifoMode
);
  ctrlStrobes_t    strb;
  logic            txDrop, rxDrop;
  logic [CNT_W-1:0] trigLvl;
  logic            unusedTxDrop;

  uart_fifo_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(2)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(cfgWe), .wrAddr(cfgAddr),
    .wrData(cfgData), .strb(strb)
  );

  uart_fifo_store #(.DEPTH(DEPTH), .WIDTH(8)) uTx (
    .clk(clk), .rstN(rstN), .fifoEn(strb.fifoEn), .flush(strb.flushTx),
    .push(hostTxWe), .pushData(hostTxData), .pop(serTxPop),
    .popData(txData), .count(txCount), .dropped(txDrop)
  );

  uart_fifo_store #(.DEPTH(DEPTH), .WIDTH(8)) uRx (
    .clk(clk), .rstN(rstN), .fifoEn(strb.fifoEn), .flush(strb.flushRx),
    .push(desRxPush), .pushData(desRxData), .pop(hostRxPop),
    .popData(rxData), .count(rxCount), .dropped(rxDrop)
  );

  assign unusedTxDrop = txDrop;

  always_comb begin
    case (strb.trigSel)
      2'b00:   trigLvl = CNT_W'(1);
      2'b01:   trigLvl = CNT_W'(4);
      2'b10:   trigLvl = CNT_W'(8);
      default: trigLvl = CNT_W'(14);
    endcase
  end

  assign rxIrq    = strb.fifoEn && (rxCount >= trigLvl);
  assign fifoMode = strb.fifoEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxOverrun <= 1'b0;
    else if (strb.flushRx) rxOverrun <= 1'b0;
    else if (rxDrop)       rxOverrun <= 1'b1;
  end

  assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushRx |=> !rxIrq);
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !strb.flushRx) |=> rxOverrun);
  assert_tx_untouched_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flushRx && !strb.flushTx && !hostTxWe && !serTxPop) |=> $stable(txCount));
endmodule

// File: tb/tb_uart_fifo_ctrl.sv
module tb_uart_fifo_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWe, hostTxWe, serTxPop, desRxPush, hostRxPop;
  logic [2:0] cfgAddr;
  logic [7:0] cfgData, hostTxData, desRxData;
  logic [7:0] txData, rxData;
  logic [4:0] txCount, rxCount;
  logic       rxIrq, rxOverrun, fifoMode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit         mEn;
  bit [1:0]   mTrig;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [7:0] mTxData, mRxData;
  bit         mOvr;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_ctrl dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .hostTxWe(hostTxWe), .hostTxData(hostTxData), .serTxPop(serTxPop),
    .txData(txData), .txCount(txCount), .desRxPush(desRxPush),
    .desRxData(desRxData), .hostRxPop(hostRxPop), .rxData(rxData),
    .rxCount(rxCount), .rxIrq(rxIrq), .rxOverrun(rxOverrun), .fifoMode(fifoMode)
  );

  function automatic int levelOf(input bit [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic compare(input string tag);
    bit expIrq;
    expIrq = mEn && (rxQ.size() >= levelOf(mTrig));
    checks++;
    if (fifoMode !== mEn || txCount !== 5'(txQ.size()) || rxCount !== 5'(rxQ.size()) ||
        txData !== mTxData || rxData !== mRxData || rxIrq !== expIrq || rxOverrun !== mOvr) begin
      errors++;
      $display("FAIL %s: act mode=%0b txc=%0d rxc=%0d txd=%h rxd=%h irq=%0b ovr=%0b exp mode=%0b txc=%0d rxc=%0d txd=%h rxd=%h irq=%0b ovr=%0b",
               tag, fifoMode, txCount, rxCount, txData, rxData, rxIrq, rxOverrun,
               mEn, txQ.size(), rxQ.size(), mTxData, mRxData, expIrq, mOvr);
    end
  endtask

  // One clock: drive at negedge, advance model, compare at next negedge.
  task automatic cycle(input string tag, input bit cw, input logic [2:0] ca,
                       input logic [7:0] cd, input bit tp, input logic [7:0] td,
                       input bit tpop, input bit rp, input logic [7:0] rd, input bit rpop);
    bit hit, fRx, fTx, cap1;
    int cap, txSz, rxSz;
    cfgWe = cw; cfgAddr = ca; cfgData = cd;
    hostTxWe = tp; hostTxData = td; serTxPop = tpop;
    desRxPush = rp; desRxData = rd; hostRxPop = rpop;
    hit  = cw && (ca == 3'd2);
    fRx  = hit && (!cd[0] || cd[1]);
    fTx  = hit && (!cd[0] || cd[2]);
    cap1 = !mEn;
    cap  = cap1 ? 1 : 16;
    txSz = txQ.size();
    rxSz = rxQ.size();
    if (fTx) txQ.delete();
    else begin
      if (tpop && txSz > 0) mTxData = txQ.pop_front();
      if (tp && txSz < cap) txQ.push_back(td);
    end
    if (fRx) begin rxQ.delete(); mOvr = 0; end
    else begin
      if (rpop && rxSz > 0) mRxData = rxQ.pop_front();
      if (rp && rxSz < cap) rxQ.push_back(rd);
      else if (rp) mOvr = 1;
    end
    if (hit) begin
      mEn = cd[0];
      if (cd[0]) mTrig = cd[7:6];
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cycle(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic cfg(input string tag, input logic [2:0] a, input logic [7:0] d);
    cycle(tag, 1, a, d, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic txPush(input string tag, input logic [7:0] d);
    cycle(tag, 0, 0, 0, 1, d, 0, 0, 0, 0);
  endtask
  task automatic txPop(input string tag);
    cycle(tag, 0, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask
  task automatic rxPush(input string tag, input logic [7:0] d);
    cycle(tag, 0, 0, 0, 0, 0, 0, 1, d, 0);
  endtask
  task automatic rxPop(input string tag);
    cycle(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: act running exp finished");
    finishRun();
  end

  initial begin
    mEn = 0; mTrig = 0; mTxData = 0; mRxData = 0; mOvr = 0;
    rstN = 0;
    cfgWe = 0; cfgAddr = 0; cfgData = 0; hostTxWe = 0; hostTxData = 0;
    serTxPop = 0; desRxPush = 0; desRxData = 0; hostRxPop = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rstN = 1;
    idle("R1 idle");

    // R8 / R10: single-byte holding mode
    rxPush("R8 hold", 8'hA1);
    rxPush("R10 overrun in hold mode", 8'hA2);
    rxPop("R9 hold pop");
    rxPop("R11 empty pop hold");
    txPush("R8 tx hold", 8'h31);
    txPush("R13 tx drop hold", 8'h32);
    txPop("R9 tx hold pop");

    // R7: other address and DMA bit
    cfg("R7 other addr", 3'd3, 8'h01);
    cfg("R2 enable", 3'd2, 8'h01);
    cfg("R7 dma bit", 3'd2, 8'h39);
    cfg("R7 other addr no disable", 3'd1, 8'h00);

    // R2 / R13 / R9: fill transmit queue
    for (int i = 0; i < 17; i++) txPush("R13 tx fill", 8'(8'h40 + i));
    for (int i = 0; i < 3; i++) txPop("R9 tx order");

    // R6: each trigger level
    for (int s = 0; s < 4; s++) begin
      cfg("R6 trig set", 3'd2, 8'({s[1:0], 6'b000011}));
      for (int i = 0; i < 16; i++) rxPush("R6 threshold", 8'(i * 7));
    end
    rxPush("R10 overrun full", 8'hEE);
    rxPop("R9 rx pop");
    rxPop("R9 rx pop");

    // R12: clear with push / pop in same cycle
    cycle("R12 rx clear with push", 1, 3'd2, 8'h03, 0, 0, 0, 1, 8'h55, 0);
    cycle("R12 tx clear with pop", 1, 3'd2, 8'h05, 0, 0, 1, 0, 0, 0);
    rxPop("R11 rx empty pop");
    txPop("R11 tx empty pop");

    // R4 / R5 isolation
    for (int i = 0; i < 5; i++) cycle("R5 setup", 0, 0, 0, 1, 8'(i), 0, 1, 8'(i + 9), 0);
    cfg("R4 rx clear only", 3'd2, 8'h03);
    cfg("R5 tx clear only", 3'd2, 8'h05);

    // R3: disable empties both, gated fields
    for (int i = 0; i < 6; i++) cycle("R3 setup", 0, 0, 0, 1, 8'(i), 0, 1, 8'(i), 0);
    cfg("R3 disable", 3'd2, 8'hC6);
    rxPush("R8 after disable", 8'h77);
    rxPush("R10 after disable", 8'h78);
    cfg("R2 re-enable", 3'd2, 8'h81);

    // R9: random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom();
      if (r[7:0] == 8'd0)
        cycle("R9 random", 1, 3'd2, {r[15:14], 3'b000, r[10:9], 1'b1}, r[16], r[31:24], r[17], r[18], r[23:16], r[19]);
      else
        cycle("R9 random", 0, 0, 0, r[16], r[31:24], r[17], r[18], r[23:16], r[19]);
    end
    finishRun();
  end
endmodule